// File: doc/BRIEF.md
# Multiplexed GPIO Pad Controller

This block owns a bank of general-purpose pads, organised in collections of eight. Each pad has a 2-bit owner field. The field chooses whether the GPIO logic drives the pad or one of three peripheral clients (A, B, C) drives it. A GPIO-owned pad takes its output-enable and output level from per-collection registers. A client-owned pad passes that client's output and output-enable straight through. The level on every pad is synchronised and can be read back, whoever owns the pad.

Software uses a synchronous byte-wide register bus. Every register is one byte, so software changes a single field by reading the byte, modifying it and writing it back. Collection `c` occupies an 8-byte window that starts at `BASE_ADDR + 8*c`. With the defaults there are 18 collections (144 pads), and the base address is 0x20.

Top module: `gpio_pinmux`

## Requirements
- R1: After reset, every owner field, output-enable bit and output bit is 0, so every pad is a GPIO input with `pad_oe` and `pad_out` low, and every readable register returns 0.
- R2: Collection `c` decodes at byte addresses `0x20 + 8*c` to `0x20 + 8*c + 7`. The offsets are:
  - +0 and +1: owner fields.
  - +2: output-enable.
  - +3: output value.
  - +6: input level.
  A write changes only the addressed collection.
- R3: The owner field of pad `p` (0 to 7) within a collection is at offset +0 for `p` < 4 and at offset +1 for `p` ≥ 4. It occupies bits `2*(p mod 4)+1 : 2*(p mod 4)`. The global pad index is `8*c + p`.
- R4: When a pad's owner field is 0, `pad_oe` equals its output-enable bit (1 = drive, 0 = input) and `pad_out` equals its output bit.
- R5: Owner field values 1, 2 and 3 route client A, B or C respectively to the pad, for both output and output-enable. The pad's output-enable and output bits then have no effect on the pad.
- R6: The input register (+6) returns `pad_in` through a two-flop synchronizer. A read strobe issued in the same cycle as a change of `pad_in`, or one cycle after it, returns the old level. A read strobe issued two cycles after the change returns the new level.
- R7: Writes to +6 and to the unused offsets +4, +5 and +7 have no effect. Those unused offsets, and addresses outside all collections, read as 0.
- R8: `bus_rdata` carries the addressed byte in the cycle after the one in which `bus_rd` is high, and is 0 in every other cycle.
- R9: The owner, output-enable and output registers read back the full byte last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| pad_in | input | 144 | Pad levels seen at the pads |
| pad_out | output | 144 | Level driven to each pad |
| pad_oe | output | 144 | Drive enable for each pad |
| cla_out | input | 144 | Client A output per pad |
| cla_oe | input | 144 | Client A drive enable per pad |
| clb_out | input | 144 | Client B output per pad |
| clb_oe | input | 144 | Client B drive enable per pad |
| clc_out | input | 144 | Client C output per pad |
| clc_oe | input | 144 | Client C drive enable per pad |

## Verification
The bench uses different data patterns in different collections, including the first and the last, so that a swapped stride or a write that reaches the wrong collection shows up. It writes an owner byte with four distinct field values, and sets each client's vectors to a different constant. A misrouted client, or a field read from the wrong bit pair or the wrong byte, therefore changes the level that the bench expects on a named pad. It issues input reads back to back around a change of `pad_in`, which pins the synchronizer latency to exactly two cycles. It writes ones to the input register, to the unused offsets and to unmapped addresses, which exposes any decode aliasing.

// File: rtl/gpio_pinmux_pkg.sv
// Shared types and register offsets for the multiplexed pad controller.
// Assumes an 8-pad collection window that is aligned to 8 bytes.
package gpio_pinmux_pkg;
    localparam int PADS_PER_COLL = 8;
    localparam int SEL_W         = 2;

    localparam logic [2:0] OFF_SEL_LO = 3'd0;
    localparam logic [2:0] OFF_SEL_HI = 3'd1;
    localparam logic [2:0] OFF_DRIVE  = 3'd2;
    localparam logic [2:0] OFF_LEVEL  = 3'd3;
    localparam logic [2:0] OFF_SENSE  = 3'd6;

    typedef enum logic [SEL_W-1:0] {
        OWN_GPIO = 2'd0,
        OWN_CL_A = 2'd1,
        OWN_CL_B = 2'd2,
        OWN_CL_C = 2'd3
    } owner_e;
endpackage

// File: rtl/gpio_sync2.sv
// Two-flop synchronizer for pad levels.
// Assumes each bit is independent: no bus coherency is needed.
module gpio_sync2 #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    // Shift the raw levels through two registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gpio_coll.sv
// One collection of eight pads: the owner, output-enable and output
// registers, the per-pad source mux and the synchronised input byte.
// Assumes that the parent has already decoded wr_en for this collection.
module gpio_coll
    import gpio_pinmux_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [2:0]                   off,
    input  logic [7:0]                   wdata,
    input  logic [PADS_PER_COLL-1:0]     pad_in,
    input  logic [2:0][PADS_PER_COLL-1:0] cl_out,
    input  logic [2:0][PADS_PER_COLL-1:0] cl_oe,
    output logic [PADS_PER_COLL-1:0]     pad_out,
    output logic [PADS_PER_COLL-1:0]     pad_oe,
    output logic [7:0]                   rd_byte
);
    logic [7:0] sel_lo, sel_hi, drive_r, level_r;
    logic [PADS_PER_COLL-1:0] sense;
    owner_e owner [PADS_PER_COLL];

    // Update the writable registers from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_lo  <= '0;
            sel_hi  <= '0;
            drive_r <= '0;
            level_r <= '0;
        end else if (wr_en) begin
            case (off)
                OFF_SEL_LO: sel_lo  <= wdata;
                OFF_SEL_HI: sel_hi  <= wdata;
                OFF_DRIVE:  drive_r <= wdata;
                OFF_LEVEL:  level_r <= wdata;
                default: ;
            endcase
        end
    end

    gpio_sync2 #(.WIDTH(PADS_PER_COLL)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(sense)
    );

    // Select the byte at the offset for reading.
    always_comb begin
        case (off)
            OFF_SEL_LO: rd_byte = sel_lo;
            OFF_SEL_HI: rd_byte = sel_hi;
            OFF_DRIVE:  rd_byte = drive_r;
            OFF_LEVEL:  rd_byte = level_r;
            OFF_SENSE:  rd_byte = sense;
            default:    rd_byte = '0;
        endcase
    end

    for (genvar p = 0; p < PADS_PER_COLL; p++) begin : g_pad
        localparam int SH = SEL_W * (p % 4);
        if (p < 4) begin : g_lo
            assign owner[p] = owner_e'(sel_lo[SH +: SEL_W]);
        end else begin : g_hi
            assign owner[p] = owner_e'(sel_hi[SH +: SEL_W]);
        end

        // Route the pad from the GPIO registers or from the selected client.
        always_comb begin
            case (owner[p])
                OWN_CL_A: begin pad_out[p] = cl_out[0][p]; pad_oe[p] = cl_oe[0][p]; end
                OWN_CL_B: begin pad_out[p] = cl_out[1][p]; pad_oe[p] = cl_oe[1][p]; end
                OWN_CL_C: begin pad_out[p] = cl_out[2][p]; pad_oe[p] = cl_oe[2][p]; end
                default:  begin pad_out[p] = level_r[p];   pad_oe[p] = drive_r[p]; end
            endcase
        end

        // R5
        client_ignores_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(wr_en && off == OFF_DRIVE && owner[p] != OWN_GPIO)
             && $stable(owner[p]) && $stable(cl_oe[0][p]) && $stable(cl_oe[1][p])
             && $stable(cl_oe[2][p])) |-> $stable(pad_oe[p]));
    end

    // R1
    reset_input_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (pad_oe == '0 && rd_byte == '0));
    // R9
    drive_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_DRIVE) |=> drive_r == $past(wdata));
    // R7
    sense_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (off == OFF_SENSE || off == 3'd4 || off == 3'd5 || off == 3'd7))
        |=> ($stable(sel_lo) && $stable(sel_hi) && $stable(drive_r) && $stable(level_r)));
endmodule

// File: rtl/gpio_pinmux.sv
// Top of the multiplexed pad controller. It decodes the byte bus onto the
// collections, registers the read data and slices the client vectors.
// Assumes that BASE_ADDR is a multiple of 8 and that the map fits the address width.
module gpio_pinmux
    import gpio_pinmux_pkg::*;
#(
    parameter int NUM_COLL  = 18,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h20
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic [7:0]                         bus_wdata,
    input  logic                               bus_wr,
    input  logic                               bus_rd,
    output logic [7:0]                         bus_rdata,
    input  logic [NUM_COLL*PADS_PER_COLL-1:0]  pad_in,
    output logic [NUM_COLL*PADS_PER_COLL-1:0]  pad_out,
    output logic [NUM_COLL*PADS_PER_COLL-1:0]  pad_oe,
    input  logic [NUM_COLL*PADS_PER_COLL-1:0]  cla_out,
    input  logic [NUM_COLL*PADS_PER_COLL-1:0]  cla_oe,
    input  logic [NUM_COLL*PADS_PER_COLL-1:0]  clb_out,
    input  logic [NUM_COLL*PADS_PER_COLL-1:0]  clb_oe,
    input  logic [NUM_COLL*PADS_PER_COLL-1:0]  clc_out,
    input  logic [NUM_COLL*PADS_PER_COLL-1:0]  clc_oe
);
    localparam int IDX_W    = ADDR_W - 3;
    localparam int END_ADDR = BASE_ADDR + 8 * NUM_COLL;

    logic [ADDR_W-1:0] addr_rel;
    logic [IDX_W-1:0]  idx;
    logic [2:0]        off;
    logic              hit;
    logic [7:0]        coll_rd [NUM_COLL];
    logic [7:0]        rd_mux;

    assign addr_rel = bus_addr - ADDR_W'(BASE_ADDR);
    assign idx      = addr_rel[ADDR_W-1:3];
    assign off      = addr_rel[2:0];
    assign hit      = ({1'b0, bus_addr} >= (ADDR_W+1)'(BASE_ADDR))
                   && ({1'b0, bus_addr} <  (ADDR_W+1)'(END_ADDR));

    for (genvar c = 0; c < NUM_COLL; c++) begin : g_coll
        localparam int LO = c * PADS_PER_COLL;
        gpio_coll u_coll (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bus_wr && hit && idx == IDX_W'(c)),
            .off    (off),
            .wdata  (bus_wdata),
            .pad_in (pad_in[LO +: PADS_PER_COLL]),
            .cl_out ({clc_out[LO +: PADS_PER_COLL], clb_out[LO +: PADS_PER_COLL],
                      cla_out[LO +: PADS_PER_COLL]}),
            .cl_oe  ({clc_oe[LO +: PADS_PER_COLL], clb_oe[LO +: PADS_PER_COLL],
                      cla_oe[LO +: PADS_PER_COLL]}),
            .pad_out(pad_out[LO +: PADS_PER_COLL]),
            .pad_oe (pad_oe[LO +: PADS_PER_COLL]),
            .rd_byte(coll_rd[c])
        );
    end

    // Pick the read byte of the addressed collection, or 0 when nothing is hit.
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_COLL; c++)
            if (hit && idx == IDX_W'(c)) rd_mux = coll_rd[c];
    end

    // Register the read data for one cycle after each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

    // R8
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);
    // R7
    unused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (!hit || off == 3'd4 || off == 3'd5 || off == 3'd7)) |=> bus_rdata == '0);
endmodule

// File: tb/tb_gpio_pinmux.sv
// Scoreboard bench: the read task queues expected bytes and a monitor checks them.
module tb_gpio_pinmux;
    localparam int NP = 144;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
    logic [NP-1:0] cla_out = '0, cla_oe = '0, clb_out = '0, clb_oe = '0, clc_out = '0, clc_oe = '0;

    int errors = 0, checks = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_seen = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_pinmux dut (.*);

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Monitor: note which edges captured a read strobe.
    always @(posedge clk) rd_seen <= bus_rd;

    // Monitor: compare each read result against the queued expectation.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                errors++; checks++;
                $display("FAIL R8: unexpected read result %02h expected none", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                check(t, bus_rdata, e);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 pad_oe", 8'(|pad_oe), 8'h00);
        check("R1 pad_out", 8'(|pad_out), 8'h00);
        rd(8'h20, 8'h00, "R1 sel");
        rd(8'h22, 8'h00, "R1 drive");
        rd(8'hAB, 8'h00, "R1 out");
        // R8: idle cycle reads 0
        @(negedge clk);
        check("R8 idle", bus_rdata, 8'h00);

        // R2 R9 R4: collections 0 and 17
        wr(8'h22, 8'h5A); wr(8'h23, 8'h3C);
        wr(8'hAA, 8'hC3); wr(8'hAB, 8'h96);
        rd(8'h22, 8'h5A, "R9 drive c0");
        rd(8'h23, 8'h3C, "R9 out c0");
        rd(8'hAA, 8'hC3, "R2 drive c17");
        rd(8'hAB, 8'h96, "R2 out c17");
        rd(8'h2A, 8'h00, "R2 c1 untouched");
        check("R4 oe c0", pad_oe[7:0], 8'h5A);
        check("R4 out c0", pad_out[7:0], 8'h3C);
        check("R4 oe c17", pad_oe[143:136], 8'hC3);
        check("R2 c1 pads", pad_oe[15:8], 8'h00);

        // R3 R5: collection 2, pads 16..23
        clb_out = '1; clb_oe = '1; clc_oe = '1;
        wr(8'h32, 8'hFF); wr(8'h33, 8'hFF);
        wr(8'h30, 8'b11_10_01_00);
        wr(8'h31, 8'h40);
        rd(8'h30, 8'hE4, "R9 sel lo");
        rd(8'h31, 8'h40, "R9 sel hi");
        check("R4 pad16", {pad_oe[16], pad_out[16]}, 8'h03);
        check("R5 pad17 A", {pad_oe[17], pad_out[17]}, 8'h00);
        check("R5 pad18 B", {pad_oe[18], pad_out[18]}, 8'h03);
        check("R5 pad19 C", {pad_oe[19], pad_out[19]}, 8'h02);
        check("R3 pad20 gpio", {pad_oe[20], pad_out[20]}, 8'h03);
        check("R3 pad23 A", {pad_oe[23], pad_out[23]}, 8'h00);
        wr(8'h32, 8'h00);
        check("R5 drive ignored pad18", 8'(pad_oe[18]), 8'h01);
        check("R4 pad16 off", 8'(pad_oe[16]), 8'h00);

        // R6: synchronizer latency on collection 5 (base 0x48)
        pad_in[47:40] = 8'hA5;
        repeat (3) @(negedge clk);
        pad_in[47:40] = 8'h3C;
        rd(8'h4E, 8'hA5, "R6 same cycle");
        rd(8'h4E, 8'hA5, "R6 one later");
        rd(8'h4E, 8'h3C, "R6 two later");

        // R7: ignored writes and zero reads
        wr(8'h4E, 8'hFF);
        wr(8'h4C, 8'hFF); wr(8'h4D, 8'hFF); wr(8'h4F, 8'hFF);
        wr(8'h10, 8'hFF); wr(8'hB2, 8'hFF);
        rd(8'h4E, 8'h3C, "R7 input write ignored");
        rd(8'h4C, 8'h00, "R7 off4");
        rd(8'h4D, 8'h00, "R7 off5");
        rd(8'h4F, 8'h00, "R7 off7");
        rd(8'h10, 8'h00, "R7 below map");
        rd(8'hB2, 8'h00, "R7 above map");
        rd(8'h22, 8'h5A, "R7 c0 drive kept");
        rd(8'h4A, 8'h00, "R7 c5 drive kept");
        check("R7 c5 pads", pad_oe[47:40], 8'h00);

        repeat (3) @(negedge clk);
        check("R8 queue drained", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule